// File: doc/BRIEF.md
# Strapping and Revision Control Registers

This block is a small system-control register slice. It holds the hardware strapping word and reports the silicon revision. Both sit behind a plain 32-bit register port that has an address, a write strobe, write data, registered read data and a one-cycle error flag. The revision is fixed by a parameter at elaboration. The upper byte of the revision picks the silicon family, and the family sets how the strapping word may be changed at run time.

On the newer family (revision bits [31:24] equal to 0x04), a write to the strapping offset can only set bits. A write to the revision offset does not change the revision; it clears the strapping bits that are 1 in the write data. On any other family, the strapping offset is a plain overwrite. On those parts the revision offset is read-only, and writing it raises the error flag.

Writes pass only while the slice is unlocked. Writing the key 0x1688A8A8 to the protect offset unlocks it, and writing any other value to that offset locks it again. A group of counter, scratch and random-data offsets is read-only and reports a write as an error.

Top module: `strap_ctl_regs`

## Requirements
- R1: After reset the strapping word equals parameter STRAP_RST, the slice is locked, and rdata_o and err_o are 0.
- R2: A write to offset 0x00 is accepted even while locked. Data 0x1688A8A8 unlocks the slice and any other value locks it. Reading 0x00 returns 1 in bit 0 when unlocked, 0 when locked, with all other bits 0.
- R3: While locked, a write to any offset other than 0x00 changes nothing and raises no error.
- R4: Newer family (REV_ID[31:24] == 0x04), unlocked: a write to offset 0x04 sets the strapping word to its old value OR the write data.
- R5: Newer family, unlocked: a write to offset 0x08 clears the strapping bits that are 1 in the write data, leaves the revision as it is, and raises no error.
- R6: Other family, unlocked: a write to offset 0x04 replaces the strapping word with the write data.
- R7: Other family, unlocked: a write to offset 0x08 raises err_o and changes no state.
- R8: A read of offset 0x08 always returns REV_ID. Both 0x04000303 and 0x04010303 select the newer family.
- R9: Unlocked writes to the read-only offsets raise err_o and change no state. The read-only offsets are the frequency evaluation register (0x10), random data (0x14), the free counter low and high words (0x18, 0x1C) and eight scratch words (0x20 to 0x3C). These offsets read as 0.
- R10: err_o is high for exactly the cycle after an offending write and low otherwise. Writes to unmapped offsets (for example 0x40) are ignored with no error and read as 0.
- R11: rdata_o shows, one cycle after an address is presented, the register contents as they were before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| we_i | input | 1 | Write strobe, one access per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench goes after the places where the two families part ways. A design that treated the strap offset as a plain write on the newer family would lose bits that were already set. One that stored the revision-offset write would corrupt the revision read-back, and one that skipped the error on the older family would accept a write to a read-only location silently. It also checks that writes while locked, including writes to read-only offsets, neither change state nor pulse the error flag, and that a wrong key re-locks the slice. Back-to-back accesses confirm that err_o drops after one cycle and that read data lags the address by exactly one cycle. A second newer-family revision value is run on its own instance to check the family decode.

// File: rtl/strap_ctl_pkg.sv
package strap_ctl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] PROT_KEY   = 32'h1688_A8A8;
  localparam logic [7:0]  FAMILY_NEW = 8'h04;

  localparam int unsigned OFF_PROT     = 'h00;
  localparam int unsigned OFF_STRAP    = 'h04;
  localparam int unsigned OFF_REV      = 'h08;
  localparam int unsigned OFF_FREQ     = 'h10;
  localparam int unsigned OFF_RNG      = 'h14;
  localparam int unsigned OFF_FCNT_LO  = 'h18;
  localparam int unsigned OFF_FCNT_HI  = 'h1C;
  localparam int unsigned OFF_SCR_BASE = 'h20;

  typedef struct packed {
    logic prot;
    logic strap;
    logic rev;
    logic ro;
  } hit_t;
endpackage

// File: rtl/strap_addr_dec.sv
module strap_addr_dec
  import strap_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_SCRATCH = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  localparam int unsigned N_FIXED_RO = 4;
  localparam int unsigned FIXED_RO [N_FIXED_RO] = '{OFF_FREQ, OFF_RNG, OFF_FCNT_LO, OFF_FCNT_HI};

  logic [N_SCRATCH-1:0]  scr_hit;
  logic [N_FIXED_RO-1:0] fix_hit;

  for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
    assign scr_hit[i] = (addr_i == ADDR_W'(OFF_SCR_BASE + 4 * i));
  end

  for (genvar j = 0; j < N_FIXED_RO; j++) begin : g_fix
    assign fix_hit[j] = (addr_i == ADDR_W'(FIXED_RO[j]));
  end

  assign hit_o.prot  = (addr_i == ADDR_W'(OFF_PROT));
  assign hit_o.strap = (addr_i == ADDR_W'(OFF_STRAP));
  assign hit_o.rev   = (addr_i == ADDR_W'(OFF_REV));
  assign hit_o.ro    = (|scr_hit) | (|fix_hit);
endmodule

// File: rtl/strap_lock.sv
module strap_lock
  import strap_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       unlocked_q <= 1'b0;
    else if (key_wr_i) unlocked_q <= (wdata_i == PROT_KEY);
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/strap_reg_core.sv
module strap_reg_core
  import strap_ctl_pkg::*;
#(
  parameter logic [31:0] REV_ID    = 32'h0400_0303,
  parameter logic [31:0] STRAP_RST = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wr_i,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] strap_o
);
  localparam bit NEW_FAM = (REV_ID[31:24] == FAMILY_NEW);

  logic [DATA_W-1:0] strap_q;

  if (NEW_FAM) begin : g_w1sc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       strap_q <= STRAP_RST;
      else if (set_wr_i) strap_q <= strap_q | wdata_i;
      else if (clr_wr_i) strap_q <= strap_q & ~wdata_i;
    end
  end else begin : g_rmw
    // clear path has no meaning on this family; top never drives it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   strap_q <= STRAP_RST;
      else if (set_wr_i && !clr_wr_i) strap_q <= wdata_i;
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/strap_ctl_regs.sv
module strap_ctl_regs
  import strap_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_SCRATCH = 8,
  parameter logic [31:0] REV_ID    = 32'h0400_0303,
  parameter logic [31:0] STRAP_RST = 32'h1200_00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam bit NEW_FAM = (REV_ID[31:24] == FAMILY_NEW);

  hit_t              hit;
  logic              unlocked_q;
  logic [DATA_W-1:0] strap_q;
  logic              we_ok;
  logic              strap_wr;
  logic              rev_clr;
  logic              err_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  strap_addr_dec #(
    .ADDR_W   (ADDR_W),
    .N_SCRATCH(N_SCRATCH)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  strap_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (we_i & hit.prot),
    .wdata_i   (wdata_i),
    .unlocked_o(unlocked_q)
  );

  assign we_ok    = we_i & unlocked_q;
  assign strap_wr = we_ok & hit.strap;
  assign rev_clr  = we_ok & hit.rev & NEW_FAM;
  assign err_d    = we_ok & (hit.ro | (hit.rev & ~NEW_FAM));

  strap_reg_core #(
    .REV_ID   (REV_ID),
    .STRAP_RST(STRAP_RST)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_wr_i(strap_wr),
    .clr_wr_i(rev_clr),
    .wdata_i (wdata_i),
    .strap_o (strap_q)
  );

  always_comb begin
    rdata_d = '0;
    if (hit.prot)       rdata_d = {{(DATA_W-1){1'b0}}, unlocked_q};
    else if (hit.strap) rdata_d = strap_q;
    else if (hit.rev)   rdata_d = REV_ID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/strap_ctl_chk.sv
module strap_ctl_chk
  import strap_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_SCRATCH = 8,
  parameter logic [31:0] REV_ID    = 32'h0400_0303
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [31:0]       strap_q,
  input logic              unlocked_q
);
  localparam bit NEW_FAM = (REV_ID[31:24] == FAMILY_NEW);
  localparam int unsigned RO_LAST = OFF_SCR_BASE + 4 * (N_SCRATCH - 1);

  logic past_ok;
  logic is_ro;
  logic is_prot;
  logic is_strap;
  logic is_rev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign is_prot  = (addr_i == ADDR_W'(OFF_PROT));
  assign is_strap = (addr_i == ADDR_W'(OFF_STRAP));
  assign is_rev   = (addr_i == ADDR_W'(OFF_REV));
  assign is_ro    = (addr_i >= ADDR_W'(OFF_FREQ)) && (addr_i <= ADDR_W'(RO_LAST)) &&
                    (addr_i[1:0] == 2'b00);

  a_r2_key_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_prot) |=> (unlocked_q == ($past(wdata_i) == PROT_KEY)));

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked_q && !is_prot) |=> ($stable(strap_q) && !err_o));

  a_r4_set_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NEW_FAM && we_i && unlocked_q && is_strap) |=>
      (strap_q == ($past(strap_q) | $past(wdata_i))));

  a_r5_rev_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NEW_FAM && we_i && unlocked_q && is_rev) |=>
      ((strap_q == ($past(strap_q) & ~$past(wdata_i))) && !err_o));

  a_r6_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!NEW_FAM && we_i && unlocked_q && is_strap) |=> (strap_q == $past(wdata_i)));

  a_r7_rev_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!NEW_FAM && we_i && unlocked_q && is_rev) |=> (err_o && $stable(strap_q)));

  a_r8_rev_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ($past(addr_i) == ADDR_W'(OFF_REV))) |-> (rdata_o == REV_ID));

  a_r9_ro_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unlocked_q && is_ro) |=> (err_o && $stable(strap_q)));

  a_r10_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (past_ok && $past(we_i && unlocked_q)));
endmodule

bind strap_ctl_regs strap_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .N_SCRATCH(N_SCRATCH),
  .REV_ID   (REV_ID)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .strap_q   (strap_q),
  .unlocked_q(unlocked_q)
);

// File: tb/tb_strap_ctl_regs.sv
module tb_strap_ctl_regs;
  localparam logic [31:0] SR  = 32'h1200_00F0;
  localparam logic [31:0] KEY = 32'h1688_A8A8;
  localparam logic [31:0] REV_A0  = 32'h0400_0303;
  localparam logic [31:0] REV_A1  = 32'h0401_0303;
  localparam logic [31:0] REV_OLD = 32'h0300_0303;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // exp_rd is the content of addr before this row's write
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h04, 32'h0,          SR,            1'b0, 4'd1},  // R1 strap reset
    '{1'b0, 8'h00, 32'h0,          32'h0,         1'b0, 4'd1},  // R1 locked
    '{1'b1, 8'h04, 32'hFFFF_FFFF,  SR,            1'b0, 4'd3},  // R3 locked write
    '{1'b0, 8'h04, 32'h0,          SR,            1'b0, 4'd3},  // R3 unchanged
    '{1'b1, 8'h3C, 32'h1,          32'h0,         1'b0, 4'd3},  // R3 locked RO, no err
    '{1'b1, 8'h00, KEY,            32'h0,         1'b0, 4'd2},  // R2 unlock
    '{1'b0, 8'h00, 32'h0,          32'h1,         1'b0, 4'd2},  // R2 unlocked
    '{1'b1, 8'h04, 32'h0000_0F01,  SR,            1'b0, 4'd4},  // R4 set
    '{1'b0, 8'h04, 32'h0,          32'h1200_0FF1, 1'b0, 4'd4},  // R4 OR result
    '{1'b1, 8'h08, 32'h1000_00F0,  REV_A0,        1'b0, 4'd5},  // R5 clear
    '{1'b0, 8'h04, 32'h0,          32'h0200_0F01, 1'b0, 4'd5},  // R5 result
    '{1'b0, 8'h08, 32'h0,          REV_A0,        1'b0, 4'd8},  // R8 rev kept
    '{1'b1, 8'h40, 32'hDEAD_BEEF,  32'h0,         1'b0, 4'd10}, // R10 unmapped
    '{1'b1, 8'h10, 32'h5,          32'h0,         1'b1, 4'd9},  // R9 freq
    '{1'b0, 8'h04, 32'h0,          32'h0200_0F01, 1'b0, 4'd10}, // R10 pulse ends
    '{1'b1, 8'h3C, 32'h7,          32'h0,         1'b1, 4'd9},  // R9 last scratch
    '{1'b1, 8'h14, 32'h7,          32'h0,         1'b1, 4'd9},  // R9 rng
    '{1'b1, 8'h1C, 32'h7,          32'h0,         1'b1, 4'd9},  // R9 counter hi
    '{1'b0, 8'h04, 32'h0,          32'h0200_0F01, 1'b0, 4'd9},  // R9 no change
    '{1'b1, 8'h00, 32'h0,          32'h1,         1'b0, 4'd2},  // R2 relock
    '{1'b0, 8'h00, 32'h0,          32'h0,         1'b0, 4'd2},  // R2 locked
    '{1'b1, 8'h04, 32'hFFFF_FFFF,  32'h0200_0F01, 1'b0, 4'd3},  // R3 locked again
    '{1'b0, 8'h04, 32'h0,          32'h0200_0F01, 1'b0, 4'd11}  // R11 latency
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr  [3];
  logic        we    [3];
  logic [31:0] wdata [3];
  logic [31:0] rdata [3];
  logic        err   [3];
  int n_chk;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  strap_ctl_regs #(.REV_ID(REV_A0), .STRAP_RST(SR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr[0]), .we_i(we[0]),
    .wdata_i(wdata[0]), .rdata_o(rdata[0]), .err_o(err[0]));

  strap_ctl_regs #(.REV_ID(REV_OLD), .STRAP_RST(SR)) dut_old (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr[1]), .we_i(we[1]),
    .wdata_i(wdata[1]), .rdata_o(rdata[1]), .err_o(err[1]));

  strap_ctl_regs #(.REV_ID(REV_A1), .STRAP_RST(SR)) dut_a1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr[2]), .we_i(we[2]),
    .wdata_i(wdata[2]), .rdata_o(rdata[2]), .err_o(err[2]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // one access; returns at the negedge after the clock edge that took it
  task automatic cyc(input int u, input logic w, input logic [7:0] a, input logic [31:0] d);
    addr[u]  = a;
    we[u]    = w;
    wdata[u] = d;
    @(negedge clk);
    we[u]    = 1'b0;
  endtask

  initial begin
    for (int u = 0; u < 3; u++) begin
      addr[u] = '0; we[u] = 1'b0; wdata[u] = '0;
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rdata in reset", rdata[0], 32'h0);
    chk("R1 err in reset", {31'b0, err[0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cyc(0, VEC[i].we, VEC[i].addr, VEC[i].wdata);
      chk($sformatf("R%0d row %0d rdata", VEC[i].req, i), rdata[0], VEC[i].exp_rd);
      chk($sformatf("R%0d row %0d err", VEC[i].req, i), {31'b0, err[0]}, {31'b0, VEC[i].exp_err});
    end

    // older family: plain overwrite, revision offset read-only
    cyc(1, 1'b1, 8'h00, KEY);
    cyc(1, 1'b1, 8'h04, 32'hA5A5_0000);
    cyc(1, 1'b0, 8'h04, 32'h0);
    chk("R6 replace", rdata[1], 32'hA5A5_0000);
    cyc(1, 1'b1, 8'h08, 32'hFFFF_FFFF);
    chk("R7 err on rev write", {31'b0, err[1]}, 32'h1);
    cyc(1, 1'b0, 8'h04, 32'h0);
    chk("R7 strap kept", rdata[1], 32'hA5A5_0000);
    chk("R10 err one cycle", {31'b0, err[1]}, 32'h0);
    cyc(1, 1'b0, 8'h08, 32'h0);
    chk("R8 old rev read", rdata[1], REV_OLD);

    // second newer-family revision
    cyc(2, 1'b1, 8'h00, KEY);
    cyc(2, 1'b1, 8'h08, 32'h0000_00F0);
    chk("R5 a1 no err", {31'b0, err[2]}, 32'h0);
    cyc(2, 1'b1, 8'h04, 32'h0);
    chk("R5 a1 cleared", rdata[2], 32'h1200_0000);
    cyc(2, 1'b0, 8'h04, 32'h0);
    chk("R4 a1 zero write sets none", rdata[2], 32'h1200_0000);
    cyc(2, 1'b0, 8'h08, 32'h0);
    chk("R8 a1 rev read", rdata[2], REV_A1);

    // reset in mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdata cleared by reset", rdata[0], 32'h0);
    rst_n = 1'b1;
    cyc(0, 1'b0, 8'h04, 32'h0);
    chk("R1 strap after reset", rdata[0], SR);
    cyc(0, 1'b0, 8'h00, 32'h0);
    chk("R1 locked after reset", rdata[0], 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule